// File: doc/BRIEF.md
# NAND Device Command Decoder

This block is the device-side front end of a small NAND flash model. It watches the host bus. On each rising edge of the write strobe, while chip enable is low, it takes the I/O byte. The two latch enables decide how that byte is treated: command latch high makes it a command, address latch high makes it an address, and both low make it data. The block decodes the commands and keeps track of which read region is in use. It also collects the column and row address over several bus cycles.

For each decoded operation it raises a one-cycle strobe, such as read, program, erase, reset, status or identify. The strobe comes with the resolved column, row and erase-block index. These strobes go to a separate array or page-buffer model. While the external busy input is high, only reset and status commands get through. Every other command is refused and flagged.

All outputs are registered. A strobe appears in the clock cycle after the one in which the rising write edge is detected.

Top module: `nand_cmd_front`

## Requirements
- R1: A byte is taken only on a rising edge of `we_n` while `ce_n` is low. `cle` high with `ale` low marks a command, `ale` high with `cle` low marks an address, and both low mark data. Bytes seen while `ce_n` is high have no effect.
- R2: Commands 00h, 01h and 50h set `ptr_region` to 0 (first half), 1 (second half) and 2 (spare) respectively, and start a read sequence. `ptr_region` never takes the value 3.
- R3: When a read or program is issued while `ptr_region` is 1, `ptr_region` returns to 0 once that operation is issued.
- R4: In a read, the third address byte raises `op_read` with `row_addr` = {third byte, second byte}. `col_addr` = region base (0, 256 or 512) + first byte, and in the spare region only bits [3:0] of the first byte are added.
- R5: The sequence 60h, two row bytes (low, then high), D0h raises `op_erase` with `row_addr` = {high, low} and `blk_idx` = `row_addr[14:5]`.
- R6: The sequence 80h, three address bytes, data bytes, 10h raises `data_vld` with `data_byte` for each data byte, then `op_program` on 10h with the column and row resolved as in R4.
- R7: A command byte outside 00h, 01h, 50h, 90h, FFh, 80h, 10h, 60h, D0h and 70h raises `err` for one cycle and changes no state.
- R8: While `busy` is high, FFh and 70h are accepted. Any other command raises `err` and is dropped, and address and data bytes are ignored.
- R9: A 10h without a completed 80h sequence, or a D0h without a completed 60h sequence, raises `err`, issues nothing and drops the sequence.
- R10: FFh raises `op_reset`, sets `ptr_region` to 0 and clears any sequence in progress.
- R11: 90h raises `op_id` and 70h raises `op_status`. At most one operation strobe is high in any cycle.
- R12: Data bytes outside a program sequence whose address phase is complete raise no `data_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe; bytes are taken on its rising edge |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| io | input | IO_W | Bus byte |
| busy | input | 1 | Array busy; restricts the accepted commands |
| op_read | output | 1 | Read issued (one cycle) |
| op_program | output | 1 | Program issued (one cycle) |
| op_erase | output | 1 | Block erase issued (one cycle) |
| op_reset | output | 1 | Reset issued (one cycle) |
| op_status | output | 1 | Status read requested (one cycle) |
| op_id | output | 1 | Identify read requested (one cycle) |
| data_vld | output | 1 | Program data byte accepted (one cycle) |
| data_byte | output | IO_W | Accepted program data byte |
| col_addr | output | COL_W | Resolved column of the last read or program |
| row_addr | output | 2*IO_W | Row of the last read, program or erase |
| blk_idx | output | BLK_W | Erase block index of the last erase |
| ptr_region | output | 2 | Read region: 0 first half, 1 second half, 2 spare |
| err | output | 1 | Refused or malformed command (one cycle) |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 10-bit column, halves of 256 columns, a 4-bit spare offset, and a block index taken from row bit 5 upward. With these values the spare region's top column 527 can be reached from an oversized column byte. The 16-bit row assembly shows whether the high and low bytes come out swapped, and an erase row of 1234h gives the non-trivial block index 145. A table of bus cycles covers the command sequences, malformed confirms and busy filtering. Directed cases then check how the region pointer returns to the first half and the resolved column and row values.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  // Command byte values the decoder recognises
  localparam logic [7:0] OPC_RD_LO    = 8'h00;
  localparam logic [7:0] OPC_RD_HI    = 8'h01;
  localparam logic [7:0] OPC_RD_SPR   = 8'h50;
  localparam logic [7:0] OPC_IDENT    = 8'h90;
  localparam logic [7:0] OPC_RESET    = 8'hFF;
  localparam logic [7:0] OPC_PGM_SET  = 8'h80;
  localparam logic [7:0] OPC_PGM_GO   = 8'h10;
  localparam logic [7:0] OPC_ERS_SET  = 8'h60;
  localparam logic [7:0] OPC_ERS_GO   = 8'hD0;
  localparam logic [7:0] OPC_STATUS   = 8'h70;

  typedef enum logic [1:0] {
    RGN_FIRST  = 2'd0,
    RGN_SECOND = 2'd1,
    RGN_SPARE  = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_PROG  = 2'd2,
    SQ_ERASE = 2'd3
  } seq_e;

  typedef enum logic [3:0] {
    CK_PTR_FIRST,
    CK_PTR_SECOND,
    CK_PTR_SPARE,
    CK_IDENT,
    CK_RESET,
    CK_PGM_SET,
    CK_PGM_GO,
    CK_ERS_SET,
    CK_ERS_GO,
    CK_STATUS,
    CK_BAD
  } cmd_kind_e;

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler #(
  parameter int IO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic            cle,
  input  logic            ale,
  input  logic [IO_W-1:0] io,
  output logic            evt_cmd,
  output logic            evt_addr,
  output logic            evt_data,
  output logic [IO_W-1:0] bus_byte
);

  logic we_q;
  logic latch_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  // rising write strobe seen with the chip selected
  assign latch_edge = we_n & ~we_q & ~ce_n;

  assign evt_cmd  = latch_edge &  cle & ~ale;
  assign evt_addr = latch_edge & ~cle &  ale;
  assign evt_data = latch_edge & ~cle & ~ale;
  assign bus_byte = io;

endmodule

// File: rtl/nand_cmd_classify.sv
module nand_cmd_classify
  import nand_fe_pkg::*;
#(
  parameter int IO_W = 8
) (
  input  logic [IO_W-1:0] cmd_byte,
  output cmd_kind_e       kind,
  output logic            busy_ok
);

  logic [7:0] code;
  assign code = cmd_byte[7:0];

  always_comb begin
    case (code)
      OPC_RD_LO:   kind = CK_PTR_FIRST;
      OPC_RD_HI:   kind = CK_PTR_SECOND;
      OPC_RD_SPR:  kind = CK_PTR_SPARE;
      OPC_IDENT:   kind = CK_IDENT;
      OPC_RESET:   kind = CK_RESET;
      OPC_PGM_SET: kind = CK_PGM_SET;
      OPC_PGM_GO:  kind = CK_PGM_GO;
      OPC_ERS_SET: kind = CK_ERS_SET;
      OPC_ERS_GO:  kind = CK_ERS_GO;
      OPC_STATUS:  kind = CK_STATUS;
      default:     kind = CK_BAD;
    endcase
  end

  // only reset and status may pass while the array is working
  assign busy_ok = (kind == CK_RESET) | (kind == CK_STATUS);

endmodule

// File: rtl/nand_addr_asm.sv
module nand_addr_asm #(
  parameter int IO_W  = 8,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             row_only,
  input  logic [IO_W-1:0]  byte_in,
  output logic [CNT_W-1:0] cnt,
  output logic [IO_W-1:0]  col_b,
  output logic [IO_W-1:0]  row_lo,
  output logic [IO_W-1:0]  row_hi
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      col_b  <= '0;
      row_lo <= '0;
      row_hi <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (take) begin
      cnt <= cnt + CNT_W'(1);
      if (row_only) begin
        if (cnt == CNT_W'(0)) row_lo <= byte_in;
        else                  row_hi <= byte_in;
      end else begin
        case (cnt)
          CNT_W'(0): col_b  <= byte_in;
          CNT_W'(1): row_lo <= byte_in;
          default:   row_hi <= byte_in;
        endcase
      end
    end
  end

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_fe_pkg::*;
#(
  parameter int IO_W       = 8,
  parameter int COL_W      = 10,
  parameter int HALF_COLS  = 256,
  parameter int SPARE_BITS = 4,
  parameter int BLK_LSB    = 5,
  parameter int BLK_W      = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_n,
  input  logic                we_n,
  input  logic                cle,
  input  logic                ale,
  input  logic [IO_W-1:0]     io,
  input  logic                busy,
  output logic                op_read,
  output logic                op_program,
  output logic                op_erase,
  output logic                op_reset,
  output logic                op_status,
  output logic                op_id,
  output logic                data_vld,
  output logic [IO_W-1:0]     data_byte,
  output logic [COL_W-1:0]    col_addr,
  output logic [2*IO_W-1:0]   row_addr,
  output logic [BLK_W-1:0]    blk_idx,
  output logic [1:0]          ptr_region,
  output logic                err
);

  localparam int ROW_W     = 2 * IO_W;
  localparam int CNT_W     = 2;
  localparam int FULL_ADDR = 3;
  localparam int ROW_ADDR  = 2;

  // column = region base + offset; the spare area uses a short offset
  function automatic logic [COL_W-1:0] eff_col(region_e r, logic [IO_W-1:0] b);
    case (r)
      RGN_SECOND: return COL_W'(HALF_COLS) + COL_W'(b);
      RGN_SPARE:  return COL_W'(2 * HALF_COLS) + COL_W'(b[SPARE_BITS-1:0]);
      default:    return COL_W'(b);
    endcase
  endfunction

  function automatic logic [ROW_W-1:0] join_row(logic [IO_W-1:0] hi, logic [IO_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BLK_W-1:0] blk_of(logic [ROW_W-1:0] row);
    return row[BLK_LSB +: BLK_W];
  endfunction

  // bus events
  logic            evt_cmd, evt_addr, evt_data;
  logic [IO_W-1:0] bus_byte;

  nand_bus_sampler #(.IO_W(IO_W)) sampler_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
    .io(io), .evt_cmd(evt_cmd), .evt_addr(evt_addr), .evt_data(evt_data),
    .bus_byte(bus_byte)
  );

  cmd_kind_e kind;
  logic      busy_ok;

  nand_cmd_classify #(.IO_W(IO_W)) classify_i (
    .cmd_byte(bus_byte), .kind(kind), .busy_ok(busy_ok)
  );

  seq_e    seq_q;
  region_e region_q;

  logic [CNT_W-1:0] cnt;
  logic [IO_W-1:0]  col_b, row_lo, row_hi;
  logic [CNT_W-1:0] addr_need;

  // named internal events
  logic cmd_accept, cmd_reject, addr_take, addr_clr, data_take;
  logic read_done, prog_go, erase_go, confirm_bad, is_confirm;

  assign addr_need   = (seq_q == SQ_ERASE) ? CNT_W'(ROW_ADDR) : CNT_W'(FULL_ADDR);
  assign cmd_accept  = evt_cmd & (~busy | busy_ok) & (kind != CK_BAD);
  assign cmd_reject  = evt_cmd & ~cmd_accept;
  assign addr_take   = evt_addr & ~busy & (seq_q != SQ_IDLE) & (cnt < addr_need);
  assign addr_clr    = cmd_accept & (kind != CK_STATUS);
  assign data_take   = evt_data & ~busy & (seq_q == SQ_PROG) & (cnt == CNT_W'(FULL_ADDR));
  assign read_done   = addr_take & (seq_q == SQ_READ) & (cnt == CNT_W'(FULL_ADDR - 1));
  assign prog_go     = cmd_accept & (kind == CK_PGM_GO) & (seq_q == SQ_PROG)
                       & (cnt == CNT_W'(FULL_ADDR));
  assign erase_go    = cmd_accept & (kind == CK_ERS_GO) & (seq_q == SQ_ERASE)
                       & (cnt == CNT_W'(ROW_ADDR));
  assign is_confirm  = (kind == CK_PGM_GO) | (kind == CK_ERS_GO);
  assign confirm_bad = cmd_accept & is_confirm & ~prog_go & ~erase_go;

  nand_addr_asm #(.IO_W(IO_W), .CNT_W(CNT_W)) addr_i (
    .clk(clk), .rst_n(rst_n), .clear(addr_clr), .take(addr_take),
    .row_only(seq_q == SQ_ERASE), .byte_in(bus_byte), .cnt(cnt),
    .col_b(col_b), .row_lo(row_lo), .row_hi(row_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q      <= SQ_IDLE;
      region_q   <= RGN_FIRST;
      op_read    <= 1'b0;
      op_program <= 1'b0;
      op_erase   <= 1'b0;
      op_reset   <= 1'b0;
      op_status  <= 1'b0;
      op_id      <= 1'b0;
      data_vld   <= 1'b0;
      data_byte  <= '0;
      col_addr   <= '0;
      row_addr   <= '0;
      blk_idx    <= '0;
      err        <= 1'b0;
    end else begin
      op_read    <= 1'b0;
      op_program <= 1'b0;
      op_erase   <= 1'b0;
      op_reset   <= 1'b0;
      op_status  <= 1'b0;
      op_id      <= 1'b0;
      data_vld   <= 1'b0;
      err        <= cmd_reject | confirm_bad;

      if (cmd_accept) begin
        case (kind)
          CK_RESET: begin
            op_reset <= 1'b1;
            seq_q    <= SQ_IDLE;
            region_q <= RGN_FIRST;
          end
          CK_STATUS: op_status <= 1'b1;
          CK_IDENT: begin
            op_id <= 1'b1;
            seq_q <= SQ_IDLE;
          end
          CK_PTR_FIRST: begin
            region_q <= RGN_FIRST;
            seq_q    <= SQ_READ;
          end
          CK_PTR_SECOND: begin
            region_q <= RGN_SECOND;
            seq_q    <= SQ_READ;
          end
          CK_PTR_SPARE: begin
            region_q <= RGN_SPARE;
            seq_q    <= SQ_READ;
          end
          CK_PGM_SET: seq_q <= SQ_PROG;
          CK_ERS_SET: seq_q <= SQ_ERASE;
          CK_PGM_GO: begin
            seq_q <= SQ_IDLE;
            if (prog_go) begin
              op_program <= 1'b1;
              col_addr   <= eff_col(region_q, col_b);
              row_addr   <= join_row(row_hi, row_lo);
              if (region_q == RGN_SECOND) region_q <= RGN_FIRST;
            end
          end
          CK_ERS_GO: begin
            seq_q <= SQ_IDLE;
            if (erase_go) begin
              op_erase <= 1'b1;
              row_addr <= join_row(row_hi, row_lo);
              blk_idx  <= blk_of(join_row(row_hi, row_lo));
            end
          end
          default: ;
        endcase
      end

      if (read_done) begin
        op_read  <= 1'b1;
        seq_q    <= SQ_IDLE;
        col_addr <= eff_col(region_q, col_b);
        row_addr <= join_row(bus_byte, row_lo);
        if (region_q == RGN_SECOND) region_q <= RGN_FIRST;
      end

      if (data_take) begin
        data_vld  <= 1'b1;
        data_byte <= bus_byte;
      end
    end
  end

  assign ptr_region = region_q;

endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             evt_cmd,
  input logic             evt_data,
  input logic             busy_ok,
  input logic             op_read,
  input logic             op_program,
  input logic             op_erase,
  input logic             op_reset,
  input logic             op_status,
  input logic             op_id,
  input logic             data_vld,
  input logic [COL_W-1:0] col_addr,
  input logic [1:0]       ptr_region,
  input logic             err
);

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_read, op_program, op_erase, op_reset, op_status, op_id}));

  // R8
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cmd && busy && !busy_ok) |=> err);

  // R2
  region_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_region != 2'd3);

  // R3
  second_revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_read || op_program) && $past(ptr_region) == 2'd1) |-> ptr_region == 2'd0);

  // R10
  reset_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_reset |-> (ptr_region == 2'd0 && !err));

  // R4
  spare_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_read && col_addr >= COL_W'(512)) |-> col_addr <= COL_W'(527));

  // R6
  data_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld |-> $past(evt_data));

  // R12
  data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld |-> !$past(busy));

endmodule

bind nand_cmd_front nand_cmd_front_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .evt_cmd(evt_cmd), .evt_data(evt_data),
  .busy_ok(busy_ok), .op_read(op_read), .op_program(op_program),
  .op_erase(op_erase), .op_reset(op_reset), .op_status(op_status),
  .op_id(op_id), .data_vld(data_vld), .col_addr(col_addr),
  .ptr_region(ptr_region), .err(err)
);

// File: tb/nand_cmd_front_tb.sv
module nand_cmd_front_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1;
  logic        we_n = 1'b1;
  logic        cle = 1'b0;
  logic        ale = 1'b0;
  logic [7:0]  io = 8'h00;
  logic        busy = 1'b0;
  logic        op_read, op_program, op_erase, op_reset, op_status, op_id;
  logic        data_vld, err;
  logic [7:0]  data_byte;
  logic [9:0]  col_addr;
  logic [15:0] row_addr;
  logic [9:0]  blk_idx;
  logic [1:0]  ptr_region;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // captured outputs from the cycle after each bus cycle
  int          cap_code;
  logic [7:0]  cap_data;
  logic [9:0]  cap_col;
  logic [15:0] cap_row;
  logic [9:0]  cap_blk;

  always #4 clk = ~clk;

  nand_cmd_front dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
    .io(io), .busy(busy), .op_read(op_read), .op_program(op_program),
    .op_erase(op_erase), .op_reset(op_reset), .op_status(op_status),
    .op_id(op_id), .data_vld(data_vld), .data_byte(data_byte),
    .col_addr(col_addr), .row_addr(row_addr), .blk_idx(blk_idx),
    .ptr_region(ptr_region), .err(err)
  );

  // result codes: 0 none, 1 read, 2 program, 3 erase, 4 reset, 5 status,
  // 6 identify, 7 data, 8 error
  function automatic int observe();
    if (err)        return 8;
    if (op_read)    return 1;
    if (op_program) return 2;
    if (op_erase)   return 3;
    if (op_reset)   return 4;
    if (op_status)  return 5;
    if (op_id)      return 6;
    if (data_vld)   return 7;
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind: 0 command, 1 address, 2 data
  task automatic bus(input int kind, input logic [7:0] b, input logic bsy,
                     input logic ce_hi);
    @(negedge clk);
    ce_n = ce_hi;
    cle  = (kind == 0);
    ale  = (kind == 1);
    io   = b;
    busy = bsy;
    we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cap_code = observe();
    cap_data = data_byte;
    cap_col  = col_addr;
    cap_row  = row_addr;
    cap_blk  = blk_idx;
    busy = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);  bus(0, b, 1'b0, 1'b0); endtask
  task automatic adr(input logic [7:0] b);  bus(1, b, 1'b0, 1'b0); endtask
  task automatic dat(input logic [7:0] b);  bus(2, b, 1'b0, 1'b0); endtask

  // {req[3:0], kind[1:0], busy, byte[7:0], expected code[3:0]}
  localparam int NV = 25;
  localparam logic [18:0] VEC [NV] = '{
    {4'd2,  2'd0, 1'b0, 8'h00, 4'd0},
    {4'd4,  2'd1, 1'b0, 8'h10, 4'd0},
    {4'd4,  2'd1, 1'b0, 8'h20, 4'd0},
    {4'd4,  2'd1, 1'b0, 8'h00, 4'd1},
    {4'd6,  2'd0, 1'b0, 8'h80, 4'd0},
    {4'd6,  2'd1, 1'b0, 8'h01, 4'd0},
    {4'd6,  2'd1, 1'b0, 8'h02, 4'd0},
    {4'd6,  2'd1, 1'b0, 8'h03, 4'd0},
    {4'd6,  2'd2, 1'b0, 8'hAB, 4'd7},
    {4'd6,  2'd0, 1'b0, 8'h10, 4'd2},
    {4'd5,  2'd0, 1'b0, 8'h60, 4'd0},
    {4'd5,  2'd1, 1'b0, 8'h34, 4'd0},
    {4'd5,  2'd1, 1'b0, 8'h12, 4'd0},
    {4'd5,  2'd0, 1'b0, 8'hD0, 4'd3},
    {4'd7,  2'd0, 1'b0, 8'h33, 4'd8},
    {4'd9,  2'd0, 1'b0, 8'h10, 4'd8},
    {4'd9,  2'd0, 1'b0, 8'h60, 4'd0},
    {4'd9,  2'd1, 1'b0, 8'h55, 4'd0},
    {4'd9,  2'd0, 1'b0, 8'hD0, 4'd8},
    {4'd8,  2'd0, 1'b1, 8'h80, 4'd8},
    {4'd8,  2'd0, 1'b1, 8'h70, 4'd5},
    {4'd8,  2'd0, 1'b1, 8'hFF, 4'd4},
    {4'd11, 2'd0, 1'b0, 8'h90, 4'd6},
    {4'd11, 2'd0, 1'b0, 8'h70, 4'd5},
    {4'd12, 2'd2, 1'b0, 8'h77, 4'd0}
  };

  initial begin
    repeat (4) @(negedge clk);
    // reset state
    chk("R10 reset region", int'(ptr_region), 0);
    chk("R11 reset strobes", observe(), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      bus(int'(VEC[i][14:13]), VEC[i][11:4], VEC[i][12], 1'b0);
      checks++;
      if (cap_code != int'(VEC[i][3:0])) begin
        fails++;
        $display("FAIL R%0d step %0d: actual %0d expected %0d",
                 VEC[i][18:15], i, cap_code, VEC[i][3:0]);
      end
    end

    // R1: bytes while deselected are ignored
    bus(0, 8'h33, 1'b0, 1'b1);
    chk("R1 deselected command", cap_code, 0);
    bus(0, 8'h01, 1'b0, 1'b1);
    chk("R1 deselected pointer", int'(ptr_region), 0);

    // R2 / R3: second half read, then revert
    cmd(8'h01);
    chk("R2 second half region", int'(ptr_region), 1);
    adr(8'h05); adr(8'h02); adr(8'h00);
    chk("R4 read strobe", cap_code, 1);
    chk("R4 second half column", int'(cap_col), 261);
    chk("R4 row join", int'(cap_row), 16'h0002);
    chk("R3 revert after read", int'(ptr_region), 0);

    // R4: spare column uses four offset bits, region stays
    cmd(8'h50);
    chk("R2 spare region", int'(ptr_region), 2);
    adr(8'h3F); adr(8'h01); adr(8'h00);
    chk("R4 spare column", int'(cap_col), 527);
    chk("R4 spare row", int'(cap_row), 16'h0001);
    chk("R2 spare kept", int'(ptr_region), 2);

    // R10: reset returns the pointer
    cmd(8'hFF);
    chk("R10 reset strobe", cap_code, 4);
    chk("R10 reset region", int'(ptr_region), 0);

    // R5: erase block index
    cmd(8'h60); adr(8'h34); adr(8'h12); cmd(8'hD0);
    chk("R5 erase strobe", cap_code, 3);
    chk("R5 erase row", int'(cap_row), 16'h1234);
    chk("R5 erase block", int'(cap_blk), 145);

    // R6 / R3: program in second half
    cmd(8'h01); cmd(8'h80); adr(8'h02); adr(8'h40); adr(8'h00);
    dat(8'hC5);
    chk("R6 data strobe", cap_code, 7);
    chk("R6 data value", int'(cap_data), 8'hC5);
    cmd(8'h10);
    chk("R6 program strobe", cap_code, 2);
    chk("R6 program column", int'(cap_col), 258);
    chk("R6 program row", int'(cap_row), 16'h0040);
    chk("R3 revert after program", int'(ptr_region), 0);

    // R7: undefined command leaves the pointer alone
    cmd(8'h01); cmd(8'h33);
    chk("R7 undefined error", cap_code, 8);
    chk("R7 pointer unchanged", int'(ptr_region), 1);

    // R8: busy blocks pointer change and address bytes
    bus(0, 8'h50, 1'b1, 1'b0);
    chk("R8 busy pointer error", cap_code, 8);
    chk("R8 busy pointer kept", int'(ptr_region), 1);
    adr(8'h00); adr(8'h00);
    bus(1, 8'h00, 1'b1, 1'b0);
    chk("R8 busy address ignored", cap_code, 0);
    adr(8'h09);
    chk("R8 read after busy", cap_code, 1);
    chk("R8 column after busy", int'(cap_col), 256);

    // R9: program confirm before full address
    cmd(8'h80); adr(8'h01); cmd(8'h10);
    chk("R9 early confirm", cap_code, 8);
    dat(8'h11);
    chk("R12 data after dropped sequence", cap_code, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule